// File: doc/BRIEF.md
# NV-DDR Command and Address Sequencer

This block takes a stream of operations for a source-synchronous NAND interface and turns each one into a single clock cycle on the flash pins. An operation is one of four kinds: a command byte, an address byte, the start of a data-in burst or the start of a data-out burst. The sequencer runs at the interface clock (nominally 100 MHz, so one cycle is 10 ns) and controls chip enable, the command and address latch strobes, the write/read direction line and the byte driven on DQ. For the two data kinds it only raises a one-cycle start strobe. The DQS capture and data path sit elsewhere.

Every timing gap is held as a whole number of clock cycles. The block stores the kind of the last cycle it issued and counts the cycles since then. An operation is let through only when that count reaches the gap that the rule table gives for the pair (previous kind, next kind). The table covers the fast or slow command/address spacing, the asymmetric turnarounds into and out of data output, and the long wait between the last address and a data load. When chip enable has been released and then reasserted, a counter of its idle time chooses between the normal and the extended setup. Two pulse inputs start further hold-offs: one blocks every cycle for about 1 µs after a feature or timing-mode change, and the other blocks only command cycles after a write-protect change.

Top module: `nvddr_cmd_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ce_n and wr_n are high and cle, ale, dq_oe, din_start, dout_start and op_ready are low.
- R2: An accepted operation shows up for exactly one cycle, in the cycle after it is accepted. The op_kind encoding is 0 command, 1 address, 2 data-in, 3 data-out. A command gives cle=1, ale=0 and dq_oe=1, with dq_out equal to op_byte. An address gives cle=0, ale=1 and dq_oe=1, with dq_out equal to op_byte. Data-in gives cle=ale=1, din_start=1, dq_oe=0 and wr_n=1. Data-out gives cle=ale=1, dout_start=1, dq_oe=0 and wr_n=0.
- R3: When the pair of cycles is any combination of command and address, or a command followed by data-in, or data-in followed by a command or address, consecutive cycles are 3 cycles apart when slow_mode=0 and 5 cycles apart when slow_mode=1. This assumes the next operation is already waiting.
- R4: An address cycle followed by a data-in cycle are 40 cycles apart.
- R5: A command, address or data-in cycle followed by a data-out cycle are 8 cycles apart.
- R6: A data-out cycle followed by a command, address or data-in cycle are 10 cycles apart. Two data-out cycles in a row may be on adjacent cycles.
- R7: The first cycle after ce_n falls appears 2 cycles after the fall. The gap is 8 cycles instead when ce_n had been high for at least 100 cycles and that first operation is data-in or data-out.
- R8: An accepted operation with op_last=1 makes ce_n rise in the cycle after that operation's cycle. ce_n then stays high for at least 2 cycles, and for exactly 2 cycles when another operation is already waiting.
- R9: A hold_req pulse blocks every cycle. A waiting operation appears 101 cycles after the clock edge that samples the pulse.
- R10: A wp_event pulse blocks only command cycles. A waiting command appears 11 cycles after the edge that samples the pulse, and address cycles during the block keep their normal spacing.
- R11: After a data-out cycle, wr_n stays low until the next cycle of another kind or until ce_n rises. wr_n is high whenever ce_n is high.
- R12: op_ready is low whenever ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, one cycle per timing step |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_mode | input | 1 | Selects the slow command/address spacing |
| op_valid | input | 1 | An operation is offered |
| op_kind | input | 2 | Operation kind: 0 command, 1 address, 2 data-in, 3 data-out |
| op_byte | input | 8 | Command or address byte |
| op_last | input | 1 | Release chip enable after this operation |
| op_ready | output | 1 | The offered operation is taken on this edge |
| hold_req | input | 1 | Pulse after a feature or timing-mode change |
| wp_event | input | 1 | Pulse on a write-protect transition |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Direction: high for write-type, low for data output |
| dq_out | output | 8 | Command or address byte for DQ |
| dq_oe | output | 1 | DQ output enable |
| din_start | output | 1 | One-cycle strobe that starts a data-in burst |
| dout_start | output | 1 | One-cycle strobe that starts a data-out burst |

## Verification
The extended chip-enable setup is the hardest case to reach. It needs chip enable to stay high for a hundred cycles and the first operation after that to be a data kind, and a normal burst never does this. The stimulus therefore waits out the idle threshold twice: once before a burst that opens with data-in, and once before a burst that opens with a command, which has to keep the short setup. The hold-offs are also measured from the cycle in which the bench drives the pulse. For the write-protect case an address is placed inside the blocked window to show that the hold-off applies only to commands.

// File: rtl/nvddr_seq_pkg.sv
// Shared types for the NV-DDR command/address sequencer.
// Assumes: op_kind encoding on the top-level port matches op_kind_e.
package nvddr_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DIN  = 2'd2,
        OP_DOUT = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        PV_NONE = 3'd0,
        PV_CMD  = 3'd1,
        PV_ADDR = 3'd2,
        PV_DIN  = 3'd3,
        PV_DOUT = 3'd4
    } prev_kind_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic prev_kind_e to_prev(input op_kind_e k);
        case (k)
            OP_CMD:  return PV_CMD;
            OP_ADDR: return PV_ADDR;
            OP_DIN:  return PV_DIN;
            default: return PV_DOUT;
        endcase
    endfunction

endpackage

// File: rtl/nvddr_gap_rules.sv
// Turnaround rule table: the minimum distance, in cycles, between the
// previous issued cycle and the next one. PV_NONE means "first cycle after
// chip enable fell", which selects the normal or the extended setup.
// Assumes all parameters are at least 1 and fit in GW bits.
module nvddr_gap_rules
    import nvddr_seq_pkg::*;
#(
    parameter int CAD_FAST  = 3,
    parameter int CAD_SLOW  = 5,
    parameter int T_WHR     = 8,
    parameter int T_RHW     = 10,
    parameter int T_ADL     = 40,
    parameter int T_CS      = 2,
    parameter int T_CS_LONG = 8,
    parameter int GW        = 6
) (
    input  prev_kind_e      prev_kind,
    input  op_kind_e        next_kind,
    input  logic            slow,
    input  logic            long_setup,
    output logic [GW-1:0]   gap
);

    localparam int WHR_F = imax(T_WHR, CAD_FAST);
    localparam int WHR_S = imax(T_WHR, CAD_SLOW);
    localparam int RHW_F = imax(T_RHW, CAD_FAST);
    localparam int RHW_S = imax(T_RHW, CAD_SLOW);
    localparam int ADL_F = imax(T_ADL, CAD_FAST);
    localparam int ADL_S = imax(T_ADL, CAD_SLOW);

    logic is_data;
    int   g;

    // Pick the gap for the (previous, next) pair
    always_comb begin
        is_data = (next_kind == OP_DIN) || (next_kind == OP_DOUT);
        g = slow ? CAD_SLOW : CAD_FAST;
        case (prev_kind)
            PV_NONE: g = (long_setup && is_data) ? T_CS_LONG : T_CS;
            PV_CMD: begin
                if (next_kind == OP_DOUT) g = slow ? WHR_S : WHR_F;
            end
            PV_ADDR: begin
                if (next_kind == OP_DOUT)     g = slow ? WHR_S : WHR_F;
                else if (next_kind == OP_DIN) g = slow ? ADL_S : ADL_F;
            end
            PV_DIN: begin
                if (next_kind == OP_DOUT) g = slow ? WHR_S : WHR_F;
            end
            PV_DOUT: begin
                if (next_kind == OP_DOUT) g = 1;
                else                      g = slow ? RHW_S : RHW_F;
            end
            default: ;
        endcase
        gap = GW'(g);
    end

endmodule

// File: rtl/nvddr_hold_timer.sv
// One-shot hold-off: a trigger pulse keeps busy high on the trigger cycle
// and for LEN cycles after the edge that samples it. Used for the
// feature-change wait and the write-protect wait.
// Assumes LEN >= 1; a new trigger restarts the window.
module nvddr_hold_timer #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load on trigger, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (trig)        cnt_q <= CW'(LEN);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = trig || (cnt_q != '0);

    // R9 R10
    trig_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);

endmodule

// File: rtl/nvddr_ce_ctrl.sv
// Chip-enable controller. It drops ce_n when an operation waits and ce_n
// has been high for at least T_CEH cycles, and raises it the cycle after
// a release is requested. A saturating idle counter marks a long idle
// period, and that mark is latched when ce_n falls.
// Assumes T_CEH <= T_LONG_IDLE and that release_req only comes while ce_n is low.
module nvddr_ce_ctrl #(
    parameter int T_CEH       = 2,
    parameter int T_LONG_IDLE = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_ce,
    input  logic release_req,
    output logic ce_n,
    output logic ce_fall,
    output logic rel_pend,
    output logic long_idle
);

    localparam int IW = $clog2(T_LONG_IDLE + 1);

    logic          ce_n_q;
    logic          rel_q;
    logic          long_q;
    logic [IW-1:0] idle_q;

    assign ce_fall = ce_n_q && want_ce && (idle_q >= IW'(T_CEH));

    // Chip enable state, idle count and long-idle mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            rel_q  <= 1'b0;
            long_q <= 1'b0;
            idle_q <= '0;
        end else begin
            rel_q <= release_req;
            if (ce_fall) begin
                ce_n_q <= 1'b0;
                long_q <= (idle_q >= IW'(T_LONG_IDLE));
                idle_q <= '0;
            end else if (rel_q) begin
                ce_n_q <= 1'b1;
                idle_q <= IW'(1);
            end else if (ce_n_q && (idle_q != IW'(T_LONG_IDLE))) begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    assign ce_n      = ce_n_q;
    assign rel_pend  = rel_q;
    assign long_idle = long_q;

    // R8
    ce_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n_q) |=> ce_n_q);

    // R8
    release_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> ce_n_q);

endmodule

// File: rtl/nvddr_cmd_seq.sv
// NV-DDR command/address sequencer top. It accepts one operation at a time,
// holds it until the turnaround rule for (previous kind, this kind) is met,
// and then drives one cycle on the flash control pins. The gap is measured by
// one saturating counter of cycles since the last issued cycle (or since
// ce_n fell). All timing parameters are in interface clock cycles.
// Assumes the flash clock is free-running and generated outside this block.
module nvddr_cmd_seq
    import nvddr_seq_pkg::*;
#(
    parameter int CAD_FAST    = 3,
    parameter int CAD_SLOW    = 5,
    parameter int T_WHR       = 8,
    parameter int T_RHW       = 10,
    parameter int T_ADL       = 40,
    parameter int T_CS        = 2,
    parameter int T_CS_LONG   = 8,
    parameter int T_CEH       = 2,
    parameter int T_LONG_IDLE = 100,
    parameter int T_FEAT      = 100,
    parameter int T_WW        = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    input  logic       op_valid,
    input  logic [1:0] op_kind,
    input  logic [7:0] op_byte,
    input  logic       op_last,
    output logic       op_ready,
    input  logic       hold_req,
    input  logic       wp_event,
    output logic       ce_n,
    output logic       cle,
    output logic       ale,
    output logic       wr_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       din_start,
    output logic       dout_start
);

    localparam int GAP_MAX = imax(imax(imax(T_ADL, T_RHW), imax(T_WHR, CAD_SLOW)),
                                  imax(imax(T_CS_LONG, T_CS), CAD_FAST));
    localparam int GW      = $clog2(GAP_MAX + 1);

    op_kind_e    kind;
    prev_kind_e  prev_q;
    logic [GW-1:0] since_q;
    logic [GW-1:0] gap;
    logic        ce_fall, rel_pend, long_idle;
    logic        feat_busy, wp_busy;
    logic        issue;

    logic       cle_q, ale_q, wr_n_q, dq_oe_q, din_q, dout_q;
    logic [7:0] dq_q;

    assign kind = op_kind_e'(op_kind);

    nvddr_gap_rules #(
        .CAD_FAST (CAD_FAST), .CAD_SLOW (CAD_SLOW), .T_WHR (T_WHR),
        .T_RHW    (T_RHW),    .T_ADL    (T_ADL),    .T_CS  (T_CS),
        .T_CS_LONG(T_CS_LONG), .GW      (GW)
    ) u_rules (
        .prev_kind  (prev_q),
        .next_kind  (kind),
        .slow       (slow_mode),
        .long_setup (long_idle),
        .gap        (gap)
    );

    nvddr_ce_ctrl #(
        .T_CEH       (T_CEH),
        .T_LONG_IDLE (T_LONG_IDLE)
    ) u_ce (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_ce     (op_valid),
        .release_req (issue && op_last),
        .ce_n        (ce_n),
        .ce_fall     (ce_fall),
        .rel_pend    (rel_pend),
        .long_idle   (long_idle)
    );

    nvddr_hold_timer #(.LEN(T_FEAT)) u_feat_hold (
        .clk (clk), .rst_n (rst_n), .trig (hold_req), .busy (feat_busy)
    );

    nvddr_hold_timer #(.LEN(T_WW)) u_wp_hold (
        .clk (clk), .rst_n (rst_n), .trig (wp_event), .busy (wp_busy)
    );

    // Acceptance: chip selected, not releasing, gap met, no hold-off active
    always_comb begin
        op_ready = !ce_n && !rel_pend && (since_q >= gap) && !feat_busy
                   && !((kind == OP_CMD) && wp_busy);
        issue    = op_valid && op_ready;
    end

    // Elapsed-cycle counter and kind of the last issued cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            prev_q  <= PV_NONE;
        end else if (ce_fall) begin
            since_q <= GW'(1);
            prev_q  <= PV_NONE;
        end else if (issue) begin
            since_q <= GW'(1);
            prev_q  <= to_prev(kind);
        end else if (since_q != GW'(GAP_MAX)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // Pin drive for the issued cycle; wr_n holds its level between cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            dq_oe_q <= 1'b0;
            dq_q    <= '0;
            din_q   <= 1'b0;
            dout_q  <= 1'b0;
            wr_n_q  <= 1'b1;
        end else begin
            cle_q   <= issue && (kind != OP_ADDR);
            ale_q   <= issue && (kind != OP_CMD);
            dq_oe_q <= issue && ((kind == OP_CMD) || (kind == OP_ADDR));
            dq_q    <= (issue && ((kind == OP_CMD) || (kind == OP_ADDR))) ? op_byte : 8'h00;
            din_q   <= issue && (kind == OP_DIN);
            dout_q  <= issue && (kind == OP_DOUT);
            if (issue)         wr_n_q <= (kind != OP_DOUT);
            else if (rel_pend) wr_n_q <= 1'b1;
        end
    end

    assign cle        = cle_q;
    assign ale        = ale_q;
    assign wr_n       = wr_n_q;
    assign dq_out     = dq_q;
    assign dq_oe      = dq_oe_q;
    assign din_start  = din_q;
    assign dout_start = dout_q;

    // R2
    kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cle_q & !ale_q, ale_q & !cle_q, din_q, dout_q}));

    // R2
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_q |-> (cle_q ^ ale_q));

    // R11
    dout_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_q |-> !wr_n_q);

    // R12
    ready_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |-> !ce_n);

    // R8
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cle_q || ale_q) |-> !ce_n);

    // R3
    cad_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cle_q ^ ale_q) |=> !(cle_q ^ ale_q));

    // R11
    idle_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |-> wr_n_q);

endmodule

// File: tb/nvddr_cmd_seq_bench.sv
// Scoreboard bench: the driver pushes each expected cycle (kind, byte, and
// distance from a reference event) and a negedge monitor pops and compares.
module nvddr_cmd_seq_bench;

    localparam int CADF = 3, CADS = 5, WHR = 8, RHW = 10, ADL = 40;
    localparam int CS = 2, CSL = 8, CEH = 2, FEATW = 102, WPW = 12;

    typedef struct {
        int kind;
        int byt;
        int refk;   // 0 previous cycle, 1 ce_n fall, 2 hold pulse, 3 wp pulse
        int gap;
        int ceh;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_mode = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [7:0] op_byte = 8'h00;
    logic op_last = 1'b0;
    logic hold_req = 1'b0;
    logic wp_event = 1'b0;
    logic op_ready, ce_n, cle, ale, wr_n, dq_oe, din_start, dout_start;
    logic [7:0] dq_out;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    exp_t sbq[$];
    int hold_cyc = 0, wp_cyc = 0;
    int ce_fall_cyc = 0, ce_rise_cyc = 0, ce_hi_len = 0;
    int last_cyc = 0, last_kind = -1;
    logic ce_n_prev = 1'b1, prev_wr_n = 1'b1;

    nvddr_cmd_seq u_nvddr_cmd_seq (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .op_valid(op_valid),
        .op_kind(op_kind), .op_byte(op_byte), .op_last(op_last),
        .op_ready(op_ready), .hold_req(hold_req), .wp_event(wp_event),
        .ce_n(ce_n), .cle(cle), .ale(ale), .wr_n(wr_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .din_start(din_start), .dout_start(dout_start)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: offer one operation, queue its expectation, wait for acceptance
    task automatic send(input int k, input int b, input bit last,
                        input int refk, input int gap, input int ceh);
        exp_t e;
        e.kind = k; e.byt = b; e.refk = refk; e.gap = gap; e.ceh = ceh;
        sbq.push_back(e);
        op_valid = 1'b1;
        op_kind  = 2'(k);
        op_byte  = 8'(b);
        op_last  = last;
        #1;
        while (!op_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        op_valid = 1'b0;
        op_last  = 1'b0;
    endtask

    // Monitor: compare every issued cycle and chip-enable edge
    always @(negedge clk) begin
        if (mon_on) begin
            int pins, epins, refc, exp_prev_wr;
            exp_t e;
            if (ce_n_prev && !ce_n) begin
                ce_fall_cyc = cyc;
                ce_hi_len   = cyc - ce_rise_cyc;
                last_kind   = -1;
            end
            if (!ce_n_prev && ce_n) begin
                ce_rise_cyc = cyc;
                chk(wr_n == 1'b1, "R11", "wr_n at ce_n rise", int'(wr_n), 1);
                chk(op_ready == 1'b0, "R12", "op_ready while ce_n high", int'(op_ready), 0);
                chk(cyc - last_cyc == 1, "R8", "ce_n rise after last cycle", cyc - last_cyc, 1);
            end
            if (cle || ale || din_start || dout_start) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected cycle", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    pins = {cle, ale, dq_oe, din_start, dout_start, wr_n};
                    case (e.kind)
                        0:       epins = 6'b101001;
                        1:       epins = 6'b011001;
                        2:       epins = 6'b110101;
                        default: epins = 6'b110010;
                    endcase
                    chk(pins == epins, "R2", "pin pattern", pins, epins);
                    if (e.kind < 2)
                        chk(int'(dq_out) == e.byt, "R2", "dq byte", int'(dq_out), e.byt);
                    chk(ce_n == 1'b0, "R8", "ce_n low during cycle", int'(ce_n), 0);
                    case (e.refk)
                        0:       refc = last_cyc;
                        1:       refc = ce_fall_cyc;
                        2:       refc = hold_cyc;
                        default: refc = wp_cyc;
                    endcase
                    case (e.refk)
                        0: chk(cyc - refc == e.gap, "R3", "gap from previous cycle (R4 R5 R6)", cyc - refc, e.gap);
                        1: chk(cyc - refc == e.gap, "R7", "gap from ce_n fall", cyc - refc, e.gap);
                        2: chk(cyc - refc == e.gap, "R9", "gap from hold pulse", cyc - refc, e.gap);
                        default: chk(cyc - refc == e.gap, "R10", "gap from wp pulse", cyc - refc, e.gap);
                    endcase
                    if (e.ceh > 0)
                        chk(ce_hi_len == e.ceh, "R8", "ce_n high length", ce_hi_len, e.ceh);
                    exp_prev_wr = (last_kind == 3) ? 0 : 1;
                    chk(int'(prev_wr_n) == exp_prev_wr, "R11", "wr_n before cycle", int'(prev_wr_n), exp_prev_wr);
                    last_cyc  = cyc;
                    last_kind = e.kind;
                end
            end
        end
        ce_n_prev = ce_n;
        prev_wr_n = wr_n;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R12: state under reset
        chk(ce_n == 1'b1, "R1", "ce_n in reset", int'(ce_n), 1);
        chk({cle, ale, dq_oe, din_start, dout_start} == 5'b0, "R1", "strobes in reset",
            int'({cle, ale, dq_oe, din_start, dout_start}), 0);
        chk(wr_n == 1'b1, "R1", "wr_n in reset", int'(wr_n), 1);
        chk(op_ready == 1'b0, "R12", "op_ready in reset", int'(op_ready), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(ce_n == 1'b1 && !cle && !ale && wr_n, "R1", "state after reset",
            int'({ce_n, cle, ale, wr_n}), 4'b1001);

        // Long idle, then burst in fast mode opening with data-in (R7 extended)
        repeat (120) @(negedge clk);
        send(2, 0,    1'b0, 1, CSL,  0);   // R7
        send(0, 8'h70, 1'b0, 0, CADF, 0);  // R3 data-in to command
        send(3, 0,    1'b0, 0, WHR,  0);   // R5
        send(3, 0,    1'b0, 0, 1,    0);   // R6 back-to-back data-out
        send(0, 8'h00, 1'b0, 0, RHW, 0);   // R6
        send(1, 8'h12, 1'b0, 0, CADF, 0);  // R3
        send(1, 8'h34, 1'b0, 0, CADF, 0);  // R3
        send(2, 0,    1'b0, 0, ADL,  0);   // R4
        send(3, 0,    1'b0, 0, WHR,  0);   // R5 data-in to data-out
        send(1, 8'h56, 1'b1, 0, RHW, 0);   // R6, R8 release

        // Slow mode burst right after release (R8 exact high time, R7 normal)
        slow_mode = 1'b1;
        send(0, 8'h90, 1'b0, 1, CS,   CEH); // R7 R8
        send(1, 8'h20, 1'b0, 0, CADS, 0);   // R3 slow
        send(0, 8'hEE, 1'b0, 0, CADS, 0);   // R3 slow
        send(2, 0,    1'b0, 0, CADS, 0);    // R3 slow command to data-in
        hold_req = 1'b1;
        hold_cyc = cyc;
        @(negedge clk);
        hold_req = 1'b0;
        send(1, 8'h01, 1'b0, 2, FEATW, 0);  // R9
        wp_event = 1'b1;
        wp_cyc = cyc;
        @(negedge clk);
        wp_event = 1'b0;
        send(1, 8'h02, 1'b0, 0, CADS, 0);   // R10 address not delayed
        send(0, 8'h10, 1'b1, 3, WPW,  0);   // R10 command delayed

        // Long idle, then burst opening with a command (R7 normal setup)
        slow_mode = 1'b0;
        repeat (130) @(negedge clk);
        send(0, 8'hA5, 1'b0, 1, CS,  0);    // R7
        send(3, 0,    1'b1, 0, WHR, 0);     // R5 R11

        repeat (20) @(negedge clk);
        chk(sbq.size() == 0, "R2", "all expected cycles seen", sbq.size(), 0);
        chk(ce_n == 1'b1 && wr_n == 1'b1, "R11", "idle after final release",
            int'({ce_n, wr_n}), 2'b11);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule